// File: doc/BRIEF.md
# Core Power Mode Sequencer

This controller moves a digital core between its active and sleep power modes. A power mode is made of three things: a core-voltage level (0 or 1), a regulator choice (linear or switching), and a flag that says whether the core sleeps. Software asks for a target mode in one request. The sequencer does not jump straight to that mode. It walks through the only legal chain of intermediate modes, one hop at a time. At each hop it drives the level, regulator and sleep controls, then waits for the analog side to report that the supply has settled.

Each hop ends in one of two ways: the settle input arrives, or a programmable timeout runs out. A request gets a one-cycle acknowledge when it is accepted. Some requests are refused instead and raise a sticky error flag:
- a request that arrives while a sequence is running;
- a mode code that does not exist;
- a frequency hint that conflicts with the target.

Three hints travel with a request. The fast hint means the core clock will run above 24 MHz. The low-frequency hint means it will run at 128 kHz or below. The low-frequency enable is given only once the core rests in linear mode at level 0.

Top module: `pwr_seq`

## Requirements
- R1: After reset the outputs show linear regulator, level 0, awake, not busy, all error flags clear. Leaving sleep always lands first on the linear regulator at the level used during sleep.
- R2: Mode codes are {sleep, switching, level}. Legal codes are 000, 001, 011, 100 and 101. The switching regulator is entered only from linear at level 1. Sleep is entered only from a linear mode at the same level.
- R3: Raising the level and enabling the switching regulator from 000 passes through 001 and then 011. The level rises only from 000.
- R4: Going to sleep at level 0 from 011 passes through 001, then 000, then 100. The level falls only from 001.
- R5: From 001, a request for 101 enters sleep at level 1 in one hop.
- R6: A request with the fast hint and a level-0 target is refused. err_illegal is set, there is no acknowledge, and the mode is unchanged.
- R7: A request with the low-frequency hint is legal only for target 000. lf_en rises when the sequence completes at 000, and falls when the next request is accepted.
- R8: busy is high from the cycle after an accepted request that needs a hop until the cycle after the final hop settles.
- R9: A request made while busy is refused and sets the sticky err_busy. The running sequence continues unchanged.
- R10: A request for codes 010, 110 or 111 is refused. err_illegal is set and the control outputs do not change.
- R11: If settle_done does not arrive within settle_limit+1 cycles of a hop starting, err_timeout is set and busy falls. The outputs hold that hop's mode.
- R12: req_ack pulses for one cycle after each accepted request. err_clr clears all three sticky error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Target mode {sleep, switching, level} |
| req_fast | input | 1 | Target clock above 24 MHz |
| req_lf | input | 1 | Target clock at or below 128 kHz |
| settle_limit | input | TW | Timeout length per hop |
| settle_done | input | 1 | Supply settled for the current hop |
| err_clr | input | 1 | Clears the sticky error flags |
| vcore_hi | output | 1 | Core-voltage level 1 |
| dcdc_en | output | 1 | Switching regulator selected |
| sleep_en | output | 1 | Core in sleep |
| lf_en | output | 1 | Low-frequency operation allowed |
| busy | output | 1 | Sequence in progress |
| req_ack | output | 1 | Request accepted (one-cycle pulse) |
| err_busy | output | 1 | Sticky: request refused while busy |
| err_illegal | output | 1 | Sticky: illegal request refused |
| err_timeout | output | 1 | Sticky: hop did not settle in time |

## Verification
The in-module assertions check the hop rules on every cycle:
- the switching regulator is entered only from linear level 1;
- sleep is entered from a linear mode at the same level;
- waking returns to linear at the same level;
- the level changes only between 000 and 001;
- no hop flips more than one control at a time;
- lf_en is high only in 000;
- refused requests leave the mode untouched.

The bench scenarios are needed for the complete hop order of each request, checked through a queue of expected modes. They also cover the timeout length, the error flags staying set across later requests, the acknowledge pulse, and a running sequence continuing after a busy-time request is refused.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic          req_fast,
  input  logic          req_lf,
  input  logic [TW-1:0] settle_limit,
  input  logic          settle_done,
  input  logic          err_clr,
  output logic          vcore_hi,
  output logic          dcdc_en,
  output logic          sleep_en,
  output logic          lf_en,
  output logic          busy,
  output logic          req_ack,
  output logic          err_busy,
  output logic          err_illegal,
  output logic          err_timeout
);
  localparam logic [2:0] LIN0 = 3'b000, LIN1 = 3'b001, SW1 = 3'b011,
                         SLP0 = 3'b100, SLP1 = 3'b101;

  logic [2:0]    mode_q, tgt_q;
  logic [TW-1:0] cnt_q;
  logic          lf_q;

  function automatic logic [2:0] next_hop(input logic [2:0] c, input logic [2:0] t);
    case (c)
      LIN0:    next_hop = (t == SLP0) ? SLP0 : LIN1;
      LIN1:    next_hop = (t == SW1 || t == SLP1) ? t : LIN0;
      SW1:     next_hop = LIN1;
      default: next_hop = {2'b00, c[0]};
    endcase
  endfunction

  wire code_ok = (req_mode == LIN0) || (req_mode == LIN1) || (req_mode == SW1) ||
                 (req_mode == SLP0) || (req_mode == SLP1);
  wire req_bad = !code_ok || (req_lf && req_mode != LIN0) || (req_fast && !req_mode[0]);
  wire accept  = req_valid && !busy && !req_bad;

  assign vcore_hi = mode_q[0];
  assign dcdc_en  = mode_q[1];
  assign sleep_en = mode_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= LIN0; tgt_q <= LIN0; cnt_q <= '0; lf_q <= 1'b0;
      lf_en <= 1'b0; busy <= 1'b0; req_ack <= 1'b0;
      err_busy <= 1'b0; err_illegal <= 1'b0; err_timeout <= 1'b0;
    end else begin
      req_ack <= accept;
      if (err_clr) begin
        err_busy <= 1'b0; err_illegal <= 1'b0; err_timeout <= 1'b0;
      end
      if (req_valid && busy) err_busy <= 1'b1;
      if (req_valid && !busy && req_bad) err_illegal <= 1'b1;
      if (accept) begin
        tgt_q <= req_mode;
        lf_q  <= req_lf;
        cnt_q <= '0;
        if (mode_q == req_mode) begin
          lf_en <= req_lf;
        end else begin
          lf_en  <= 1'b0;
          busy   <= 1'b1;
          mode_q <= next_hop(mode_q, req_mode);
        end
      end else if (busy) begin
        if (settle_done) begin
          cnt_q <= '0;
          if (mode_q == tgt_q) begin
            busy  <= 1'b0;
            lf_en <= lf_q;
          end else begin
            mode_q <= next_hop(mode_q, tgt_q);
          end
        end else if (cnt_q == settle_limit) begin
          busy        <= 1'b0;
          err_timeout <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_WAKE_LINEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_en) |-> !dcdc_en && vcore_hi == $past(vcore_hi)); // R1
  AST_SW_FROM_LIN1: assert property (@(posedge clk) disable iff (rst)
    $rose(dcdc_en) |-> $past(mode_q) == LIN1); // R2
  AST_SLEEP_FROM_LIN: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_en) |-> !$past(dcdc_en) && vcore_hi == $past(vcore_hi)); // R2
  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (rst)
    $rose(vcore_hi) |-> $past(mode_q) == LIN0); // R3
  AST_LEVEL_DOWN: assert property (@(posedge clk) disable iff (rst)
    $fell(vcore_hi) |-> $past(mode_q) == LIN1); // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_q ^ $past(mode_q)) <= 1); // R3
  AST_LF_LIN0: assert property (@(posedge clk) disable iff (rst)
    lf_en |-> mode_q == LIN0); // R7
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
    req_valid && busy |=> err_busy && !req_ack); // R9
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy && req_bad |=> $stable(mode_q) && err_illegal && !req_ack); // R10
endmodule

// File: tb/pwr_seq_tb_top.sv
module pwr_seq_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_fast = 1'b0, req_lf = 1'b0, err_clr = 1'b0;
  logic [2:0] req_mode = 3'b000;
  logic [7:0] settle_limit = 8'd20;
  logic settle_done = 1'b0;
  logic vcore_hi, dcdc_en, sleep_en, lf_en, busy, req_ack, err_busy, err_illegal, err_timeout;

  int checks = 0, errors = 0;
  bit auto_settle = 1'b1;
  logic [2:0] exp_q[$];
  logic last_ack;

  always #2 clk = ~clk;

  pwr_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_fast(req_fast), .req_lf(req_lf), .settle_limit(settle_limit),
    .settle_done(settle_done), .err_clr(err_clr), .vcore_hi(vcore_hi),
    .dcdc_en(dcdc_en), .sleep_en(sleep_en), .lf_en(lf_en), .busy(busy),
    .req_ack(req_ack), .err_busy(err_busy), .err_illegal(err_illegal),
    .err_timeout(err_timeout)
  );

  wire [2:0] mode_now = {sleep_en, dcdc_en, vcore_hi};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // settle model: pulse settle_done after three busy cycles
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      settle_done = 1'b0;
      if (auto_settle && busy) begin
        cnt++;
        if (cnt == 3) begin settle_done = 1'b1; cnt = 0; end
      end else cnt = 0;
    end
  end

  // monitor: every observed mode change must match the queue front
  initial begin
    logic [2:0] prev = 3'b000;
    forever begin
      @(negedge clk);
      if (!rst && mode_now !== prev) begin
        if (exp_q.size() == 0) check("R2 unexpected hop", {29'd0, mode_now}, {29'd0, prev});
        else check("R3 hop order", {29'd0, mode_now}, {29'd0, exp_q.pop_front()});
        prev = mode_now;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic expect_hops(input logic [2:0] a, input int n, input logic [2:0] b, input logic [2:0] c);
    exp_q.push_back(a);
    if (n > 1) exp_q.push_back(b);
    if (n > 2) exp_q.push_back(c);
  endtask

  task automatic send(input logic [2:0] m, input logic f, input logic l);
    @(negedge clk);
    req_mode = m; req_fast = f; req_lf = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_fast = 1'b0; req_lf = 1'b0;
    last_ack = req_ack;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic clear_errs();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset mode", {29'd0, mode_now}, 32'd0);
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    check("R1 reset errs", {29'd0, err_busy, err_illegal, err_timeout}, 32'd0);

    // R3: raise to switching level 1
    expect_hops(3'b001, 2, 3'b011, 3'b000);
    send(3'b011, 1'b0, 1'b0);
    check("R12 ack pulse", {31'd0, last_ack}, 32'd1);
    check("R8 busy after accept", {31'd0, busy}, 32'd1);
    @(negedge clk);
    check("R12 ack one cycle", {31'd0, req_ack}, 32'd0);
    wait_idle();
    check("R8 busy dropped", {31'd0, busy}, 32'd0);
    check("R3 final mode", {29'd0, mode_now}, 32'h3);

    // R4: down to sleep level 0
    expect_hops(3'b001, 3, 3'b000, 3'b100);
    send(3'b100, 1'b0, 1'b0);
    wait_idle();
    check("R4 final mode", {29'd0, mode_now}, 32'h4);

    // R1: wake lands on linear level 0, then up to switching
    expect_hops(3'b000, 3, 3'b001, 3'b011);
    send(3'b011, 1'b0, 1'b0);
    wait_idle();
    check("R1 wake path end", {29'd0, mode_now}, 32'h3);

    // R5: sleep at level 1
    expect_hops(3'b001, 2, 3'b101, 3'b000);
    send(3'b101, 1'b0, 1'b0);
    wait_idle();
    check("R5 sleep level1", {29'd0, mode_now}, 32'h5);

    // R1: wake at level 1 to linear
    expect_hops(3'b001, 1, 3'b000, 3'b000);
    send(3'b001, 1'b0, 1'b0);
    wait_idle();
    check("R1 wake level1", {29'd0, mode_now}, 32'h1);

    // R10: illegal codes
    send(3'b010, 1'b0, 1'b0);
    check("R10 no ack", {31'd0, last_ack}, 32'd0);
    check("R10 err_illegal", {31'd0, err_illegal}, 32'd1);
    check("R10 mode held", {29'd0, mode_now}, 32'h1);
    send(3'b110, 1'b0, 1'b0);
    check("R10 mode held 110", {29'd0, mode_now}, 32'h1);
    check("R10 sticky", {31'd0, err_illegal}, 32'd1);
    clear_errs();
    check("R12 err_clr", {31'd0, err_illegal}, 32'd0);

    // R6: fast hint needs level 1
    send(3'b000, 1'b1, 1'b0);
    check("R6 refused", {30'd0, last_ack, err_illegal}, 32'd1);
    check("R6 mode held", {29'd0, mode_now}, 32'h1);
    clear_errs();
    expect_hops(3'b011, 1, 3'b000, 3'b000);
    send(3'b011, 1'b1, 1'b0);
    check("R6 fast level1 ok", {31'd0, last_ack}, 32'd1);
    wait_idle();

    // R7: low-frequency hint
    send(3'b001, 1'b0, 1'b1);
    check("R7 lf bad target", {30'd0, last_ack, err_illegal}, 32'd1);
    clear_errs();
    expect_hops(3'b001, 2, 3'b000, 3'b000);
    send(3'b000, 1'b0, 1'b1);
    check("R7 lf_en low in flight", {31'd0, lf_en}, 32'd0);
    wait_idle();
    @(negedge clk);
    check("R7 lf_en set", {31'd0, lf_en}, 32'd1);
    expect_hops(3'b001, 1, 3'b000, 3'b000);
    send(3'b001, 1'b0, 1'b0);
    check("R7 lf_en cleared", {31'd0, lf_en}, 32'd0);
    wait_idle();

    // R9: request while busy
    expect_hops(3'b000, 2, 3'b100, 3'b000);
    send(3'b100, 1'b0, 1'b0);
    send(3'b011, 1'b0, 1'b0);
    check("R9 no ack busy", {31'd0, last_ack}, 32'd0);
    check("R9 err_busy", {31'd0, err_busy}, 32'd1);
    check("R8 still busy", {31'd0, busy}, 32'd1);
    wait_idle();
    check("R9 path unchanged", {29'd0, mode_now}, 32'h4);
    check("R9 sticky", {31'd0, err_busy}, 32'd1);
    clear_errs();

    // R11: timeout
    auto_settle = 1'b0;
    settle_limit = 8'd5;
    expect_hops(3'b000, 1, 3'b000, 3'b000);
    send(3'b001, 1'b0, 1'b0);
    begin
      int n = 0;
      for (int i = 0; i < 50 && busy; i++) begin n++; @(negedge clk); end
      check("R11 busy length", n, 32'd6);
    end
    check("R11 err_timeout", {31'd0, err_timeout}, 32'd1);
    check("R11 mode held", {29'd0, mode_now}, 32'h0);
    auto_settle = 1'b1;
    settle_limit = 8'd20;

    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule